// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

The block takes a 64-bit request word written by an originating processor and that processor's index. It marks the requested software-generated interrupt pending in every processor the word selects. To do this it steps through a static table of per-processor affinity values at a rate of one processor per clock, in ascending index order. For each selected processor it raises a one-hot pending-set strobe and presents the interrupt ID alongside it.

There are two routing modes. In targeted mode a processor is selected when its three upper affinity levels equal those in the request and the bit of the 16-bit level-0 target list indexed by its level-0 affinity is set. The block keeps a working copy of the list and clears each bit as it is used. As a result, a second processor with the same affinity is not selected, and the walk stops as soon as the working list is empty. In broadcast mode every processor except the sender is selected, and the target list plays no part.

A new request is taken only while the block is idle. A one-cycle done pulse closes each walk. The done pulse carries a flag that tells whether any processor was marked, so that a global state update is triggered only when one is needed.

Top module: `sgi_dispatch`

## Requirements
- R1: The request word is decoded as follows: target list [15:0], level-1 affinity [23:16], interrupt ID [27:24], level-2 affinity [39:32], routing mode [40] (1 = broadcast), level-3 affinity [55:48]. All other bits have no effect. `pend_id` shows the interrupt ID throughout the walk.
- R2: `req_ready` is high exactly when the block is idle. A request is accepted on a clock where `req_valid` and `req_ready` are both high. A request offered while busy is held off until the walk ends.
- R3: The walk starts in the cycle after acceptance, at processor 0, and visits one processor per clock in ascending index order. A strobe for processor k appears only in the k-th walk cycle, counting from 0.
- R4: In targeted mode, processor k is selected only when its affinity levels 3, 2 and 1 equal the request's levels and its level-0 affinity is below 16 with that bit set in the working target list. A level-0 affinity of 16 or more never matches.
- R5: On a targeted match, the processor's level-0 bit is cleared from the working list. A later processor with the same affinity is therefore not selected.
- R6: In targeted mode, `done` is raised in the cycle where the working list becomes zero. A request whose list is zero from the start finishes in its first walk cycle with no strobe.
- R7: In broadcast mode every processor except `req_src` is selected, and the target list is ignored.
- R8: If the walk does not stop early, `done` is raised in the cycle that visits processor NUM_CPU-1. `busy` is low in the cycle after `done`.
- R9: `any_set` is high only together with `done`, and only when at least one strobe was raised during that walk.
- R10: A target-list bit that no processor matches is dropped silently. The walk then runs to the last processor and finishes normally.
- R11: At most one `pend_set` bit is high in any cycle, and none is high while the block is idle.
- R12: After reset the block is idle: `req_ready`=1, `busy`=0, `done`=0, `any_set`=0, and `pend_set`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request word is offered |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_word | input | 64 | Request word (field layout in R1) |
| req_src | input | IDX_W | Index of the sending processor |
| aff_table | input | NUM_CPU*32 | Affinity of each processor. Entry k sits at [32k+31:32k] as {aff3, aff2, aff1, aff0} |
| pend_set | output | NUM_CPU | One-hot strobe that marks the interrupt pending in a processor |
| pend_id | output | 4 | Interrupt ID of the request being walked |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | Pulse in the last cycle of a walk |
| any_set | output | 1 | With done: at least one processor was marked |

## Verification
The bench builds the block with NUM_CPU=6. This is small enough that every walk, full or early, ends within a few cycles. The affinity table is filled to exercise the corner cases:
- two processors share one affinity, which exposes target-list consumption;
- one processor has a level-0 value of 20, which can never match;
- one processor has non-zero upper levels, which exercises the hierarchical compare.

Broadcast walks are run with the sender first in the table and last in the table. A request is also offered back to back with a running walk, to show the hold-off.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int AFF_W   = 8;
  localparam int ID_W    = 4;
  localparam int TL_W    = 16;
  localparam int TLIDX_W = $clog2(TL_W);
  localparam int WORD_W  = 64;
  localparam int ENTRY_W = 4 * AFF_W;

  typedef struct packed {
    logic [AFF_W-1:0] a3;
    logic [AFF_W-1:0] a2;
    logic [AFF_W-1:0] a1;
    logic [AFF_W-1:0] a0;
  } aff_t;

  typedef struct packed {
    logic             bcast;
    logic [ID_W-1:0]  id;
    logic [AFF_W-1:0] a3;
    logic [AFF_W-1:0] a2;
    logic [AFF_W-1:0] a1;
    logic [TL_W-1:0]  tl;
  } req_t;

  function automatic req_t unpack_req(input logic [WORD_W-1:0] w);
    req_t r;
    r.tl    = w[15:0];
    r.a1    = w[23:16];
    r.id    = w[27:24];
    r.a2    = w[39:32];
    r.bcast = w[40];
    r.a3    = w[55:48];
    return r;
  endfunction

  function automatic logic upper_eq(input aff_t a, input req_t r);
    return (a.a3 == r.a3) && (a.a2 == r.a2) && (a.a1 == r.a1);
  endfunction

  function automatic logic [TL_W-1:0] level0_bit(input logic [AFF_W-1:0] a0);
    logic [TL_W-1:0] m;
    m = '0;
    if (a0 < AFF_W'(TL_W)) m[a0[TLIDX_W-1:0]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/sgi_req_decode.sv
module sgi_req_decode
  import sgi_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output req_t              req
);
  logic unused_word_bits;
  assign unused_word_bits = ^{word[31:28], word[47:41], word[63:56]};
  assign req = unpack_req(word);
endmodule

// File: rtl/sgi_aff_match.sv
module sgi_aff_match
  import sgi_pkg::*;
(
  input  aff_t            aff,
  input  req_t            req,
  input  logic [TL_W-1:0] work_tl,
  input  logic            is_src,
  output logic            hit,
  output logic [TL_W-1:0] hit_bit
);
  logic [TL_W-1:0] own_bit;
  logic            tgt_hit;

  assign own_bit = level0_bit(aff.a0);
  assign tgt_hit = upper_eq(aff, req) && ((own_bit & work_tl) != '0);

  always_comb begin
    if (req.bcast) begin
      hit     = ~is_src;
      hit_bit = '0;
    end else begin
      hit     = tgt_hit;
      hit_bit = tgt_hit ? own_bit : '0;
    end
  end
endmodule

// File: rtl/sgi_walker.sv
module sgi_walker
  import sgi_pkg::*;
#(
  parameter  int NUM_CPU = 8,
  localparam int IDX_W   = $clog2(NUM_CPU)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  req_t             req_in,
  input  logic [IDX_W-1:0] src_in,
  input  logic             hit,
  input  logic [TL_W-1:0]  hit_bit,
  output req_t             req_q,
  output logic [IDX_W-1:0] src_q,
  output logic [IDX_W-1:0] idx_q,
  output logic [TL_W-1:0]  tl_q,
  output logic             busy_q,
  output logic             fin,
  output logic             any_out
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CPU - 1);

  logic            any_q;
  logic [TL_W-1:0] tl_nxt;
  logic            last_cpu;
  logic            list_empty;

  assign tl_nxt     = tl_q & ~hit_bit;
  assign last_cpu   = (idx_q == LAST_IDX);
  assign list_empty = ~req_q.bcast && (tl_nxt == '0);
  assign fin        = busy_q && (last_cpu || list_empty);
  assign any_out    = fin && (any_q || hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      tl_q   <= '0;
      any_q  <= 1'b0;
      req_q  <= '0;
      src_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      tl_q   <= req_in.tl;
      any_q  <= 1'b0;
      req_q  <= req_in;
      src_q  <= src_in;
    end else if (busy_q) begin
      tl_q  <= tl_nxt;
      any_q <= any_q | hit;
      if (fin) busy_q <= 1'b0;
      else     idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter  int NUM_CPU = 8,
  localparam int IDX_W   = $clog2(NUM_CPU)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [WORD_W-1:0]          req_word,
  input  logic [IDX_W-1:0]           req_src,
  input  logic [NUM_CPU*ENTRY_W-1:0] aff_table,
  output logic [NUM_CPU-1:0]         pend_set,
  output logic [ID_W-1:0]            pend_id,
  output logic                       busy,
  output logic                       done,
  output logic                       any_set
);
  req_t             dec_req;
  req_t             walk_req;
  logic [IDX_W-1:0] walk_src;
  logic [IDX_W-1:0] walk_idx;
  logic [TL_W-1:0]  work_tl;
  logic             accept;
  logic             cpu_hit;
  logic             walk_hit;
  logic             walk_bcast;
  logic [TL_W-1:0]  cpu_hit_bit;
  aff_t             cur_aff;

  assign req_ready  = ~busy;
  assign accept     = req_valid & ~busy;
  assign cur_aff    = aff_t'(aff_table[walk_idx*ENTRY_W +: ENTRY_W]);
  assign walk_hit   = busy & cpu_hit;
  assign walk_bcast = walk_req.bcast;

  sgi_req_decode u_dec (
    .word (req_word),
    .req  (dec_req)
  );

  sgi_aff_match u_match (
    .aff     (cur_aff),
    .req     (walk_req),
    .work_tl (work_tl),
    .is_src  (walk_idx == walk_src),
    .hit     (cpu_hit),
    .hit_bit (cpu_hit_bit)
  );

  sgi_walker #(.NUM_CPU(NUM_CPU)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .req_in  (dec_req),
    .src_in  (req_src),
    .hit     (walk_hit),
    .hit_bit (busy ? cpu_hit_bit : '0),
    .req_q   (walk_req),
    .src_q   (walk_src),
    .idx_q   (walk_idx),
    .tl_q    (work_tl),
    .busy_q  (busy),
    .fin     (done),
    .any_out (any_set)
  );

  assign pend_id = walk_req.id;

  always_comb begin
    pend_set = '0;
    if (walk_hit) pend_set[walk_idx] = 1'b1;
  end
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter  int NUM_CPU = 8,
  localparam int IDX_W   = $clog2(NUM_CPU)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               accept,
  input logic               busy,
  input logic               done,
  input logic               any_set,
  input logic [NUM_CPU-1:0] pend_set,
  input logic [3:0]         pend_id,
  input logic               walk_bcast,
  input logic [IDX_W-1:0]   walk_src
);
  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_set));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pend_set == '0) && !done && !any_set);
  a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == !busy);
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  a_r8_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r9_any_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    any_set |-> done);
  a_r7_skip_src: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && walk_bcast) |-> !pend_set[walk_src]);
  a_r1_id_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pend_id));
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .accept     (accept),
  .busy       (busy),
  .done       (done),
  .any_set    (any_set),
  .pend_set   (pend_set),
  .pend_id    (pend_id),
  .walk_bcast (walk_bcast),
  .walk_src   (walk_src)
);

// File: tb/sgi_dispatch_tb_top.sv
module sgi_dispatch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU       = 6;
  localparam int IW         = $clog2(NCPU);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [63:0]      req_word = '0;
  logic [IW-1:0]    req_src = '0;
  logic [NCPU*32-1:0] aff_table;
  logic [NCPU-1:0]  pend_set;
  logic [3:0]       pend_id;
  logic             busy, done, any_set;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  int ta0 [NCPU] = '{0, 1, 0, 1, 20, 5};
  int ta1 [NCPU] = '{0, 0, 1, 0, 0, 3};
  int ta2 [NCPU] = '{0, 0, 0, 0, 0, 2};
  int ta3 [NCPU] = '{0, 0, 0, 0, 0, 1};

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int k = 0; k < NCPU; k++)
      aff_table[k*32 +: 32] = {8'(ta3[k]), 8'(ta2[k]), 8'(ta1[k]), 8'(ta0[k])};
  end

  sgi_dispatch #(.NUM_CPU(NCPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_word(req_word), .req_src(req_src), .aff_table(aff_table),
    .pend_set(pend_set), .pend_id(pend_id), .busy(busy), .done(done),
    .any_set(any_set)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Reference model: each queue entry is one walk cycle:
  // bits [15:0] strobe mask, bit 16 done, bit 17 any.
  int   exp_q[$];
  int   exp_id = 0;
  int   seen_mask = 0;
  int   walk_cycles = 0;

  function automatic void plan_walk(input logic [63:0] w, input int src);
    int tl, bc, hit, anyv, fin, a1, a2, a3;
    tl = int'(w[15:0]); bc = int'(w[40]);
    a1 = int'(w[23:16]); a2 = int'(w[39:32]); a3 = int'(w[55:48]);
    exp_id = int'(w[27:24]);
    anyv = 0;
    for (int k = 0; k < NCPU; k++) begin
      hit = 0;
      if (bc != 0) hit = (k != src) ? 1 : 0;
      else if (ta3[k] == a3 && ta2[k] == a2 && ta1[k] == a1 && ta0[k] < 16 &&
               ((tl >> ta0[k]) & 1) != 0) begin
        hit = 1;
        tl = tl & ~(1 << ta0[k]);
      end
      if (hit != 0) anyv = 1;
      fin = (k == NCPU-1 || (bc == 0 && tl == 0)) ? 1 : 0;
      exp_q.push_back((hit << k) | (fin << 16) | ((fin & anyv) << 17));
      if (fin != 0) break;
    end
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      bit was_idle;
      int e;
      was_idle = (exp_q.size() == 0);
      e = was_idle ? 0 : exp_q[0];
      check("R2 ready", int'(req_ready), was_idle ? 1 : 0);
      check("R2 busy", int'(busy), was_idle ? 0 : 1);
      check("R3 strobes", int'(pend_set), e & 16'hFFFF);
      check("R8 done", int'(done), (e >> 16) & 1);
      check("R9 any_set", int'(any_set), (e >> 17) & 1);
      if (!was_idle) begin
        check("R1 pend_id", int'(pend_id), exp_id);
        seen_mask = seen_mask | int'(pend_set);
        walk_cycles++;
        void'(exp_q.pop_front());
      end else if (req_valid) begin
        plan_walk(req_word, int'(req_src));
      end
    end
  end

  function automatic logic [63:0] mk(input int tl, input int a1, input int id,
                                     input int a2, input int bc, input int a3);
    logic [63:0] w;
    w = '0;
    w[15:0] = 16'(tl); w[23:16] = 8'(a1); w[27:24] = 4'(id);
    w[39:32] = 8'(a2); w[40] = 1'(bc); w[55:48] = 8'(a3);
    return w;
  endfunction

  task automatic send(input logic [63:0] w, input int src);
    @(posedge clk); #1;
    req_valid = 1'b1; req_word = w; req_src = IW'(src);
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic settle();
    do @(negedge clk); while (!req_ready);
    #1;
  endtask

  task automatic run(input string tag, input logic [63:0] w, input int src,
                     input int exp_mask, input int exp_cycles);
    seen_mask = 0; walk_cycles = 0;
    send(w, src);
    settle();
    check({tag, " mask"}, seen_mask, exp_mask);
    check({tag, " cycles"}, walk_cycles, exp_cycles);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    check("R12 ready", int'(req_ready), 1);
    check("R12 busy", int'(busy), 0);
    check("R12 strobes", int'(pend_set), 0);
    check("R12 done", int'(done), 0);
    rst_n = 1'b1;
    // R6: early exit at cpu1 once bit1 is consumed; R5: cpu3 not hit
    run("R5 dup", mk(16'h0002, 0, 3, 0, 0, 0), 0, 6'b000010, 2);
    run("R6 early", mk(16'h0003, 0, 4, 0, 0, 0), 0, 6'b000011, 2);
    // R4 + R1: upper levels match only cpu5; junk in unused bits
    run("R1 R4 upper", mk(16'h0020, 3, 9, 2, 0, 1) | 64'hFF00_FE00_F000_0000,
        0, 6'b100000, 6);
    // R10: bit7 unmatched, full walk
    run("R10 drop", mk(16'h0081, 0, 2, 0, 0, 0), 0, 6'b000001, 6);
    // R9: no match at all
    run("R9 none", mk(16'h0004, 0, 1, 0, 0, 0), 0, 0, 6);
    // R7: broadcast skips sender, list ignored
    run("R7 bc src2", mk(16'h0001, 0, 5, 0, 1, 0), 2, 6'b111011, 6);
    run("R7 bc src5", mk(16'h0000, 7, 6, 9, 1, 4), 5, 6'b011111, 6);
    run("R7 bc src0", mk(16'hFFFF, 0, 15, 0, 1, 0), 0, 6'b111110, 6);
    // R6: empty list ends in first walk cycle
    run("R6 empty", mk(16'h0000, 0, 8, 0, 0, 0), 0, 0, 1);
    // R4: level-1 compare selects cpu2
    run("R4 a1", mk(16'h0001, 1, 11, 0, 0, 0), 0, 6'b000100, 3);
    // R4/R5: full list; cpu3 consumed, cpu4 (aff0=20) never matches
    run("R4 R5 full", mk(16'hFFFF, 0, 12, 0, 0, 0), 0, 6'b000011, 6);
    // R2: second request offered while busy is held off
    seen_mask = 0; walk_cycles = 0;
    send(mk(16'h0020, 3, 13, 2, 0, 1), 0);
    send(mk(16'h0002, 0, 14, 0, 0, 0), 0);
    settle();
    check("R2 holdoff cycles", walk_cycles, 8);
    check("R2 holdoff mask", seen_mask, 6'b100010);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) cyc <= cyc + 1;
endmodule